// File: doc/BRIEF.md
# Word-Serial Unified Montgomery Multiplier

This block computes a Montgomery product one bit of the multiplier operand at a time. Each bit step adds the selected copy of the multiplicand, picks the reduction quotient as the running sum's least significant bit, adds the modulus when that bit is one, and halves the sum. The multiplicand, the modulus and the running sum are cut into words of `W` bits. The datapath touches one word per clock and passes two one-bit carries from each word to the next.

A mode input selects between integer (prime-field) arithmetic and carry-free polynomial arithmetic over GF(2)[x]. In polynomial mode every carry is killed, so each addition becomes an XOR. In integer mode the implied Montgomery constant is R = 2^(N+2). The run uses N+2 bit steps, and each step takes N/W+1 words to hold the two guard bits. With inputs below 2M the result is already below 2M, so no final subtraction is made. A caller pulses `start` with the operands on the inputs, waits for `done`, and reads `z_out`.

Top module: `mm_montgomery`

## Requirements
- R1: In integer mode, for odd M and x, y below both 2M and 2^N, the result satisfies z_out·2^(N+2) ≡ x·y (mod M).
- R2: In integer mode under the same input bounds, z_out is below 2M with no final subtraction step, and no carry leaves the top word.
- R3: In polynomial mode (`gf_mode`=1) with M having bit 0 set, z_out·x^(N+2) ≡ x·y modulo M as polynomials over GF(2), all carries are zero, and z_out is below 2^N.
- R4: `busy` stays high for exactly (N+2)·(N/W+1) cycles after the edge that accepts `start`, which is 90 cycles for N=16, W=4.
- R5: `done` is high for exactly one cycle, on the first cycle after `busy` falls, and `busy` is low while `done` is high.
- R6: While the block is idle and `start` is low, `z_out` holds its value.
- R7: A `start` pulse while `busy` is high is ignored: the running operation finishes on its original operands with its original length.
- R8: After reset, `busy`=0, `done`=0 and `z_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| gf_mode | input | 1 | 0 = integer arithmetic, 1 = carry-free polynomial arithmetic |
| x_in | input | N | Multiplier operand, scanned one bit per step from bit 0 |
| y_in | input | N | Multiplicand operand |
| m_in | input | N | Modulus, bit 0 set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| z_out | output | N+1 | Result |

## Verification
The bench uses a small setup (N=16, W=4) and checks congruence with its own big-integer and carry-less arithmetic, not with a copy of the step recurrence. The integer patterns cover zero operands, unit operands, operands at 2M-1 (the widest the range allows), M=3 and M near 2^N, and a pseudo-random spread. Together they tell apart a wrong quotient choice, a lost carry between words, a lost top guard word, and a missing shift bit. The polynomial patterns reuse operands whose integer carries would be non-zero, so any carry leaking into that mode breaks the congruence. Other runs inject a second `start` mid-operation and time the `busy` window and the `done` pulse.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic {
    MM_IDLE = 1'b0,
    MM_RUN  = 1'b1
  } mm_state_t;
endpackage

// File: rtl/mm_word_cell.sv
module mm_word_cell #(
  parameter int W = 4
) (
  input  logic         gf,
  input  logic         xi,
  input  logic         first,
  input  logic         q_held,
  input  logic         ca_in,
  input  logic         cb_in,
  input  logic [W-1:0] z_w,
  input  logic [W-1:0] y_w,
  input  logic [W-1:0] m_w,
  output logic         q_now,
  output logic         ca_out,
  output logic         cb_out,
  output logic [W-1:0] sum
);
  // Word add with optional carry kill: in polynomial mode it is a plain XOR.
  function automatic logic [W:0] add_kill(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic cin,
                                          input logic kill);
    logic [W:0] r;
    if (kill) r = {1'b0, a ^ b};
    else      r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    return r;
  endfunction

  logic [W:0] part_a;
  logic [W:0] part_b;

  always_comb begin
    part_a = add_kill(z_w, xi ? y_w : '0, ca_in, gf);
    q_now  = first ? part_a[0] : q_held;
    part_b = add_kill(part_a[W-1:0], q_now ? m_w : '0, cb_in, gf);
  end

  assign ca_out = part_a[W];
  assign cb_out = part_b[W];
  assign sum    = part_b[W-1:0];
endmodule

// File: rtl/mm_seq.sv
module mm_seq #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done,
  output logic first_word,
  output logic last_word,
  output logic [$clog2(N+2)-1:0]   bit_idx,
  output logic [$clog2(N/W+1)-1:0] word_idx
);
  import mm_pkg::*;
  localparam int K  = N + 2;
  localparam int NW = N / W + 1;
  localparam int BW = $clog2(K);
  localparam int JW = $clog2(NW);

  mm_state_t state;

  assign busy       = (state == MM_RUN);
  assign accept     = start && !busy;
  assign first_word = busy && (word_idx == '0);
  assign last_word  = (word_idx == JW'(NW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MM_IDLE;
      bit_idx  <= '0;
      word_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state    <= MM_RUN;
        bit_idx  <= '0;
        word_idx <= '0;
      end else if (busy) begin
        if (last_word) begin
          word_idx <= '0;
          if (bit_idx == BW'(K - 1)) begin
            state <= MM_IDLE;
            done  <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end else begin
          word_idx <= word_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mm_montgomery.sv
module mm_montgomery #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         gf_mode,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  output logic         busy,
  output logic         done,
  output logic [N:0]   z_out
);
  localparam int K  = N + 2;
  localparam int NW = N / W + 1;
  localparam int ZW = NW * W;
  localparam int BW = $clog2(K);
  localparam int JW = $clog2(NW);

  logic [K-1:0]  xr;
  logic [ZW-1:0] yr, mr, zr;
  logic          gf_r;
  logic          q_r, ca_r, cb_r;
  logic [W-2:0]  hold;

  logic          accept, first_word, last_word;
  logic [BW-1:0] bit_idx;
  logic [JW-1:0] word_idx;
  logic          q_now, ca_out, cb_out;
  logic [W-1:0]  sum_word, z_w, y_w, m_w;
  int            wi;

  mm_seq #(.N(N), .W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .done(done), .first_word(first_word), .last_word(last_word),
    .bit_idx(bit_idx), .word_idx(word_idx)
  );

  always_comb begin
    wi  = int'(word_idx);
    z_w = zr[wi*W +: W];
    y_w = yr[wi*W +: W];
    m_w = mr[wi*W +: W];
  end

  mm_word_cell #(.W(W)) u_cell (
    .gf(gf_r), .xi(xr[bit_idx]), .first(first_word), .q_held(q_r),
    .ca_in(first_word ? 1'b0 : ca_r), .cb_in(first_word ? 1'b0 : cb_r),
    .z_w(z_w), .y_w(y_w), .m_w(m_w),
    .q_now(q_now), .ca_out(ca_out), .cb_out(cb_out), .sum(sum_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr   <= '0;
      yr   <= '0;
      mr   <= '0;
      zr   <= '0;
      gf_r <= 1'b0;
      q_r  <= 1'b0;
      ca_r <= 1'b0;
      cb_r <= 1'b0;
      hold <= '0;
    end else if (accept) begin
      xr   <= {2'b00, x_in};
      yr   <= {{(ZW-N){1'b0}}, y_in};
      mr   <= {{(ZW-N){1'b0}}, m_in};
      gf_r <= gf_mode;
      zr   <= '0;
      ca_r <= 1'b0;
      cb_r <= 1'b0;
    end else if (busy) begin
      ca_r <= ca_out;
      cb_r <= cb_out;
      hold <= sum_word[W-1:1];
      if (first_word) q_r <= q_now;
      // one-bit right shift across words: low bit of this word tops the previous one
      if (!first_word) zr[(wi-1)*W +: W] <= {sum_word[0], hold};
      if (last_word)   zr[wi*W +: W]     <= {1'b0, sum_word[W-1:1]};
    end
  end

  assign z_out = zr[N:0];
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int N  = 16,
  parameter int ZW = 20,
  parameter int W  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [N:0]    z_out,
  input logic [ZW-1:0] zr,
  input logic [ZW-1:0] mr,
  input logic          gf_r,
  input logic          first_word,
  input logic          last_word,
  input logic          ca_out,
  input logic          cb_out,
  input logic [W-1:0]  sum_word
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_z_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(z_out));

  assert_gf_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && gf_r) |-> (!ca_out && !cb_out));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_word && !gf_r) |-> (!ca_out && !cb_out));

  assert_lsb_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && first_word) |-> (sum_word[0] == 1'b0));

  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gf_r) |-> ({1'b0, zr} < {mr, 1'b0}));

  assert_top_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gf_r) |-> (zr[ZW-1:N+1] == '0));
endmodule

bind mm_montgomery mm_chk #(.N(N), .ZW(ZW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .z_out(z_out), .zr(zr), .mr(mr), .gf_r(gf_r),
  .first_word(first_word), .last_word(last_word),
  .ca_out(ca_out), .cb_out(cb_out), .sum_word(sum_word)
);

// File: tb/mm_montgomery_bench.sv
`timescale 1ns/1ps
module mm_montgomery_bench;
  localparam int N = 16;
  localparam int W = 4;
  localparam int LAT = (N + 2) * (N / W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic gf_mode = 1'b0;
  logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
  logic busy, done;
  logic [N:0] z_out;

  int checks = 0;
  int errors = 0;
  longint cycles = 0;
  longint seed = 64'h1234_5678;

  always #10 clk = ~clk;

  mm_montgomery #(.N(N), .W(W)) u_mm_montgomery (
    .clk(clk), .rst_n(rst_n), .start(start), .gf_mode(gf_mode),
    .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .busy(busy), .done(done), .z_out(z_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clmul(input longint a, input longint b);
    longint r = 0;
    for (int i = 0; i < 32; i++) if (b[i]) r ^= (a << i);
    return r;
  endfunction

  function automatic longint pmod(input longint a, input longint m);
    longint r = a;
    int dm = 0;
    for (int i = 0; i < 63; i++) if (m[i]) dm = i;
    for (int i = 62; i >= dm; i--) if (r[i]) r ^= (m << (i - dm));
    return r;
  endfunction

  function automatic longint nxt();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return (seed >>> 33) & 64'h7FFF_FFFF;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input longint x, input longint y, input longint m,
                        input bit gf, input bit poke);
    int cnt = 0;
    longint z, zhold;
    @(negedge clk);
    x_in = N'(x); y_in = N'(y); m_in = N'(m); gf_mode = gf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 1000) begin
      if (busy) cnt++;
      if (poke && cnt == 10) begin
        // R7: second start mid-run with different operands
        start = 1'b1; x_in = ~x_in; y_in = y_in ^ 16'h5A5A; gf_mode = ~gf;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == LAT, poke ? "R7 length" : "R4 busy cycles", cnt, LAT);
    check(!busy && done, "R5 done with busy low", {busy, done}, 1);
    z = longint'(z_out);
    if (!gf) begin
      check(((z << (N + 2)) % m) == ((x * y) % m), poke ? "R7 result" : "R1 congruence",
            (z << (N + 2)) % m, (x * y) % m);
      check(z < 2 * m, "R2 below 2M", z, 2 * m);
    end else begin
      check(pmod((z << (N + 2)) ^ clmul(x, y), m) == 0, poke ? "R7 result" : "R3 poly congruence",
            pmod(z << (N + 2), m), pmod(clmul(x, y), m));
      check(z < (longint'(1) << N), "R3 below 2^N", z, longint'(1) << N);
    end
    zhold = z;
    @(negedge clk);
    check(!done, "R5 single-cycle done", done, 0);
    repeat (3) @(negedge clk);
    check(longint'(z_out) == zhold, "R6 hold while idle", z_out, zhold);
  endtask

  initial begin
    longint mods[5] = '{3, 32769, 65535, 47011, 4661};
    longint pmods[3] = '{32773, 69, 65535};
    repeat (3) @(negedge clk);
    check(!busy && !done && z_out == 0, "R8 reset state", {busy, done, z_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && z_out == 0, "R8 after release", {busy, done, z_out}, 0);

    foreach (mods[k]) begin
      longint m = mods[k];
      longint lim = (2 * m < 65536) ? 2 * m : 65536;
      run_op(0, lim - 1, m, 1'b0, 1'b0);
      run_op(1, 1, m, 1'b0, 1'b0);
      run_op(lim - 1, lim - 1, m, 1'b0, 1'b0);
      for (int r = 0; r < 3; r++) run_op(nxt() % lim, nxt() % lim, m, 1'b0, 1'b0);
    end
    run_op(1, 1, 1, 1'b0, 1'b0);
    run_op(12345, 54321, 47011, 1'b0, 1'b1);

    foreach (pmods[k]) begin
      run_op(65535, 65535, pmods[k], 1'b1, 1'b0);
      run_op(0, 4321, pmods[k], 1'b1, 1'b0);
      for (int r = 0; r < 3; r++) run_op(nxt() % 65536, nxt() % 65536, pmods[k], 1'b1, 1'b0);
    end
    run_op(40000, 777, 32773, 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule